// File: doc/BRIEF.md
# Auto-Increment Two-Wire Register Port

This block is the serial slave front end of a timekeeping macro. It owns a small register file of clock and control bytes and exposes it to an external master over a two-wire open-drain bus. SCL and SDA are oversampled with the system clock through synchronizers. The block finds START and STOP conditions, matches its fixed 7-bit device address and acknowledges every byte it receives. A write transfer loads the internal byte pointer with its first data byte and then stores each later byte at the pointer. A read transfer returns bytes from wherever the pointer stands. The pointer advances after every data byte and wraps at the end of the file.

SDA is modelled as an input plus a pull-low enable. The bus line is the wired-AND of the master and the slave. The whole register image is presented in parallel to the timekeeping logic beside it. The only data path is the serial bus, which carries its own acknowledge handshake, so the block has no valid/ready stream port. A power-fail input, synchronous to the system clock, cancels any transfer, clears the pointer and makes the block deaf to the bus while it is high.

Top module: `i2c_rtc_regport`

## Requirements
- R1: After reset every register reads zero on `reg_image`, the pointer is 0 and `sda_oe` is low (line released).
- R2: Only the address byte 0xD0 (write) or 0xD1 (read) is acknowledged. For any other address byte SDA stays released, and no byte is acknowledged or stored until the next START.
- R3: In a write transfer, the first byte after the address sets the pointer to its low 3 bits. Each later byte is stored in register `ptr` (byte k sits at `reg_image[8k+7:8k]`) and the pointer then advances. Every such byte is acknowledged.
- R4: In a read transfer the slave shifts out register `ptr` MSB first, starting at the current pointer value, and the pointer advances after each byte.
- R5: The pointer wraps from 7 to 0, for both reads and writes.
- R6: If the master does not acknowledge a read byte, the transfer ends. SDA stays released for any further clocks until a new START.
- R7: A repeated START restarts address matching and keeps the pointer value.
- R8: STOP ends the transfer. Bytes clocked after it without a START are neither acknowledged nor stored.
- R9: While `pwr_fail` is high, the slave releases SDA on the next cycle, the pointer is held at 0 and bus activity is ignored (no acknowledge, no store).
- R10: `sda_oe` changes only while the synchronized SCL is low. An acknowledge or data bit is therefore held for the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| pwr_fail | input | 1 | Supply out of tolerance: abort, clear pointer, ignore bus |
| reg_image | output | 64 | All register bytes, byte k at bits 8k+7..8k |

## Verification
The checker tests every cycle that the drive only changes while SCL is low and that SDA stays released whenever the engine is idle. It also checks that power-fail releases SDA and clears the pointer one cycle later, that a register store only happens from the write-data state, and that the bit counter stays in range. Pointer loading, the read data order, wrap-around, repeated START, the ignored wrong-address and post-STOP traffic and the resumption after power-fail are sequence properties. Only the bench's bus transactions show them, checked against a behavioural register and pointer model.

// File: rtl/rtcport_pkg.sv
package rtcport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } port_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronizes both bus lines and derives edge and bus-condition events.
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl = scl_sync[SYNC_STAGES-1];
  assign sda_lvl = sda_sync[SYNC_STAGES-1];

  // Events are suppressed while the bus is gated off.
  assign scl_rise  = !gate &&  scl_lvl && !scl_q;
  assign scl_fall  = !gate && !scl_lvl &&  scl_q;
  assign start_evt = !gate &&  scl_lvl &&  scl_q &&  sda_q && !sda_lvl;
  assign stop_evt  = !gate &&  scl_lvl &&  scl_q && !sda_q &&  sda_lvl;
endmodule

// File: rtl/rtc_regfile.sv
// Byte register file: one write port, one read port, full parallel image.
module rtc_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [PTR_W-1:0]           waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [PTR_W-1:0]           raddr,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] image
);
  logic [DATA_W-1:0] cells [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[k] <= '0;
      else if (we && waddr == PTR_W'(k))
        cells[k] <= wdata;
    end
    assign image[k*DATA_W +: DATA_W] = cells[k];
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_rtc_regport.sv
module i2c_rtc_regport #(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  localparam int        DATA_W      = 8,
  localparam int        PTR_W       = $clog2(NUM_REGS),
  localparam int        CNT_W       = $clog2(DATA_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic                       pwr_fail,
  output logic [NUM_REGS*DATA_W-1:0] reg_image
);
  import rtcport_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  port_state_e       state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, rdata;
  logic [PTR_W-1:0]  ptr, ptr_next;
  logic              rw_bit, first_byte, master_ack;
  logic              reg_we;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .gate(pwr_fail),
    .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  rtc_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .waddr(ptr), .wdata(rx_sh),
    .raddr(ptr), .rdata(rdata), .image(reg_image)
  );

  assign ptr_next = (ptr == PTR_W'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;

  // A data byte (not the pointer byte) is complete at the eighth falling SCL.
  assign reg_we = (state == ST_WR) && scl_fall && (bitcnt == FULL) && !first_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ptr        <= '0;
      rw_bit     <= 1'b0;
      first_byte <= 1'b0;
      master_ack <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (pwr_fail) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            rx_sh  <= {rx_sh[DATA_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == FULL) begin
            if (state == ST_ADDR) begin
              if (rx_sh[DATA_W-1:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw_bit <= rx_sh[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              if (first_byte) begin
                ptr        <= rx_sh[PTR_W-1:0];
                first_byte <= 1'b0;
              end else begin
                ptr <= ptr_next;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw_bit) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[DATA_W-1];
              state  <= ST_RD;
            end else begin
              sda_oe     <= 1'b0;
              first_byte <= 1'b1;
              state      <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == FULL) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_next;
              state  <= ST_RD_ACK;
            end else begin
              tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
              sda_oe <= ~tx_sh[DATA_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            master_ack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (master_ack) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[DATA_W-1];
              bitcnt <= '0;
              state  <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtcport_checker.sv
module rtcport_checker #(
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_fail,
  input logic             sda_oe,
  input logic             scl_lvl,
  input logic             start_evt,
  input logic             reg_we,
  input logic [2:0]       state,
  input logic [CNT_W-1:0] bitcnt,
  input logic [PTR_W-1:0] ptr
);
  import rtcport_pkg::*;

  assert_pf_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);

  assert_pf_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> ptr == '0);

  assert_drive_hold_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_lvl) && !$past(pwr_fail)) |-> $stable(sda_oe));

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'(ST_IDLE) && !start_evt && !pwr_fail) |=> !sda_oe);

  assert_store_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (state == 3'(ST_WR) && !pwr_fail));

  assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(8));
endmodule

bind i2c_rtc_regport rtcport_checker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_rtcport_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sda_oe(sda_oe),
  .scl_lvl(scl_lvl), .start_evt(start_evt), .reg_we(reg_we),
  .state(state), .bitcnt(bitcnt), .ptr(ptr)
);

// File: tb/test_i2c_rtc_regport.sv
module test_i2c_rtc_regport;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        pwr_fail = 1'b0;
  logic        sda_oe;
  logic [63:0] reg_image;
  wire         sda_line = sda_m & ~sda_oe;

  i2c_rtc_regport i_i2c_rtc_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .pwr_fail(pwr_fail), .reg_image(reg_image)
  );

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] mregs [8];
  int mptr = 0;
  bit cmp_on = 1'b0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] model_img();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = mregs[k];
    return v;
  endfunction

  // Register image versus model, every clock while the bus is quiet (R3).
  always @(negedge clk)
    if (cmp_on) chk(reg_image == model_img(), "R3 image", reg_image, model_img());

  // Drive changes must fall in SCL low time (R10).
  always @(negedge clk) begin
    if (rst_n && !pwr_fail && sda_oe !== prev_oe)
      chk(!(prev_scl && scl), "R10 drive change under SCL high", {63'd0, scl}, 64'd0);
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      bad++;
      $display("FAIL watchdog (all) actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(10);
    scl = 1'b1;   wt(20);
    sda_m = 1'b0; wt(20);
    scl = 1'b0;   wt(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(10);
    scl = 1'b1;   wt(20);
    sda_m = 1'b1; wt(20);
  endtask

  task automatic sbit(input logic b);
    sda_m = b; wt(10);
    scl = 1'b1; wt(20);
    scl = 1'b0; wt(10);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(10);
    scl = 1'b1;   wt(10);
    b = sda_line; wt(10);
    scl = 1'b0;   wt(10);
  endtask

  task automatic wbyte(input logic [7:0] d, input bit want_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    rbit(a);
    chk(a == !want_ack, tag, {63'd0, a}, {63'd0, !want_ack});
  endtask

  task automatic rbyte(input bit give_ack, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    sbit(!give_ack);
    chk(d == exp, tag, {56'd0, d}, {56'd0, exp});
  endtask

  task automatic m_store(input logic [7:0] d);
    mregs[mptr] = d;
    mptr = (mptr + 1) % 8;
  endtask

  task automatic m_read_exp(output logic [7:0] e);
    e = mregs[mptr];
    mptr = (mptr + 1) % 8;
  endtask

  task automatic gap();
    wt(5);
    cmp_on = 1'b1;
    wt(30);
    cmp_on = 1'b0;
  endtask

  initial begin
    logic [7:0] e;
    logic b;
    for (int k = 0; k < 8; k++) mregs[k] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1: reset state
    chk(reg_image == 64'd0, "R1 image after reset", reg_image, 64'd0);
    chk(sda_oe == 1'b0, "R1 line released", {63'd0, sda_oe}, 64'd0);

    // R3: pointer byte then three data bytes
    bus_start();
    wbyte(8'hD0, 1'b1, "R2 write address ack");
    wbyte(8'h02, 1'b1, "R3 pointer ack"); mptr = 2;
    wbyte(8'h11, 1'b1, "R3 data ack"); m_store(8'h11);
    wbyte(8'h22, 1'b1, "R3 data ack"); m_store(8'h22);
    wbyte(8'h33, 1'b1, "R3 data ack"); m_store(8'h33);
    bus_stop();
    gap();

    // R7: set pointer, repeated START, read two bytes (R4)
    bus_start();
    wbyte(8'hD0, 1'b1, "R2 write address ack");
    wbyte(8'h03, 1'b1, "R3 pointer ack"); mptr = 3;
    bus_start();
    wbyte(8'hD1, 1'b1, "R7 read address ack after repeated start");
    m_read_exp(e); rbyte(1'b1, e, "R4 read byte at pointer");
    m_read_exp(e); rbyte(1'b0, e, "R4 read byte after increment");
    bus_stop();
    gap();

    // R4: read from current pointer; R6: NACK leaves line released
    bus_start();
    wbyte(8'hD1, 1'b1, "R2 read address ack");
    m_read_exp(e); rbyte(1'b0, e, "R4 read from current pointer");
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      chk(b == 1'b1, "R6 released after NACK", {63'd0, b}, 64'd1);
    end
    bus_stop();
    gap();

    // R5: wrap on write and on read
    bus_start();
    wbyte(8'hD0, 1'b1, "R2 write address ack");
    wbyte(8'h06, 1'b1, "R3 pointer ack"); mptr = 6;
    wbyte(8'hA6, 1'b1, "R5 data ack"); m_store(8'hA6);
    wbyte(8'hA7, 1'b1, "R5 data ack"); m_store(8'hA7);
    wbyte(8'hA0, 1'b1, "R5 data ack after wrap"); m_store(8'hA0);
    bus_stop();
    gap();
    bus_start();
    wbyte(8'hD0, 1'b1, "R2 write address ack");
    wbyte(8'h07, 1'b1, "R3 pointer ack"); mptr = 7;
    bus_start();
    wbyte(8'hD1, 1'b1, "R7 read address ack");
    m_read_exp(e); rbyte(1'b1, e, "R5 read last register");
    m_read_exp(e); rbyte(1'b1, e, "R5 read wraps to register 0");
    m_read_exp(e); rbyte(1'b0, e, "R5 read register 1");
    bus_stop();
    gap();

    // R2: foreign address ignored
    bus_start();
    wbyte(8'hA0, 1'b0, "R2 foreign address not acked");
    wbyte(8'h00, 1'b0, "R2 byte after foreign address not acked");
    wbyte(8'hEE, 1'b0, "R2 byte after foreign address not acked");
    bus_stop();
    gap();

    // R8: STOP ends transfer; later bytes without START ignored
    bus_start();
    wbyte(8'hD0, 1'b1, "R2 write address ack");
    wbyte(8'h00, 1'b1, "R3 pointer ack"); mptr = 0;
    wbyte(8'h55, 1'b1, "R3 data ack"); m_store(8'h55);
    bus_stop();
    wt(10);
    scl = 1'b0; wt(10);
    wbyte(8'hC3, 1'b0, "R8 byte after STOP not acked");
    wbyte(8'h3C, 1'b0, "R8 byte after STOP not acked");
    sda_m = 1'b1; wt(10);
    scl = 1'b1; wt(20);
    gap();

    // R9: power fail mid-transfer
    bus_start();
    wbyte(8'hD0, 1'b1, "R2 write address ack");
    wbyte(8'h04, 1'b1, "R3 pointer ack"); mptr = 4;
    wbyte(8'h99, 1'b1, "R3 data ack"); m_store(8'h99);
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    pwr_fail = 1'b1;
    wt(2);
    chk(sda_oe == 1'b0, "R9 released under power fail", {63'd0, sda_oe}, 64'd0);
    for (int i = 0; i < 5; i++) sbit(1'b1);
    rbit(b);
    chk(b == 1'b1, "R9 no ack under power fail", {63'd0, b}, 64'd1);
    bus_start();
    wbyte(8'hD0, 1'b0, "R9 address ignored under power fail");
    wbyte(8'h77, 1'b0, "R9 data ignored under power fail");
    bus_stop();
    gap();
    pwr_fail = 1'b0;
    mptr = 0;
    wt(10);
    bus_start();
    wbyte(8'hD1, 1'b1, "R9 read address ack after recovery");
    m_read_exp(e); rbyte(1'b0, e, "R9 pointer cleared by power fail");
    bus_stop();
    gap();

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule